// File: doc/BRIEF.md
# Edge Capture Timer

This block timestamps both transitions of an external capture signal. A free-running counter advances on every system clock. The capture input first passes through a synchronizer. When the synchronized level goes from low to high, the current count is stored in a rise timestamp register. When it goes from high to low, the count is stored in a separate fall timestamp register. Each capture raises an interrupt request, and a small status word records which edges are pending.

Software reads the two timestamps through a registered read port and subtracts them to get a pulse width or a period. The status word also reports two conditions. One is that the counter wrapped between two captures, so a difference is ambiguous. The other is that an edge replaced a timestamp that had not yet been read. Reading the status word acknowledges the interrupt and clears these conditions.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, irq is 0, both timestamp registers read 0, the status word reads 0 and the counter starts from 0.
- R2: The counter advances by one every clock and wraps from 0xFFFF to 0. Reading address 3 returns the count held at the clock edge that samples rd_en.
- R3: The capture input takes a two-flop synchronizer and an edge detector. A rising edge applied just after clock edge k loads the count held at edge k+2, which is value(k)+2, into the rise register (address 0). The new value is readable within 4 clocks of the input change.
- R4: A falling edge loads the count into a separate fall register (address 1), with the same latency as R3. It leaves the rise register unchanged.
- R5: irq is 1 no later than 3 clocks after a capturing edge. Status bit 0 marks a pending rise and bit 1 marks a pending fall.
- R6: Reading the status word (address 2) returns its value from before the read. The read then clears all status bits, and irq falls on the next clock unless a new capture arrives on that same edge.
- R7: Status bit 2 is a sticky overflow flag. It is set when a capture occurs after the counter has wrapped since the previous capture.
- R8: An edge that arrives while its register holds a value that has not been read still updates the register. A rise sets status bit 3 and a fall sets status bit 4.
- R9: rd_valid is 1 exactly one clock after rd_en, and rd_data is valid in that same cycle.
- R10: Input pulses that stay high for 4 clocks and low for 4 clocks are all captured, with no edge lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_in | input | 1 | Asynchronous capture signal |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | 0 rise stamp, 1 fall stamp, 2 status, 3 live count |
| rd_valid | output | 1 | Read data valid, one clock after rd_en |
| rd_data | output | 16 | Read data; status is in bits 4:0 |
| irq | output | 1 | Capture interrupt request |

## Verification
The status word and the interrupt show a wrong internal state at the ports soon after it arises. A stuck unread marker shows as a wrong overrun bit in the next status read. A lost wrap record shows as a clear bit 2 after a period longer than the counter range. An off-by-one in synchronizer depth shifts every captured stamp by a fixed amount, so the first timestamp read after any edge exposes it. The irq level is checked 3 clocks after each edge and again after each status read.

// File: rtl/ect_pkg.sv
package ect_pkg;

  // Addresses decoded by the register read port.
  typedef enum logic [1:0] {
    A_RISE  = 2'd0,
    A_FALL  = 2'd1,
    A_STAT  = 2'd2,
    A_COUNT = 2'd3
  } reg_addr_e;

  // Status word. The first field listed is the most significant bit.
  typedef struct packed {
    logic fall_ovr;   // bit 4
    logic rise_ovr;   // bit 3
    logic wrapped;    // bit 2
    logic fall_pend;  // bit 1
    logic rise_pend;  // bit 0
  } stat_t;

  localparam int STAT_W = $bits(stat_t);

  // Returns the status word with the events of one cycle applied.
  function automatic stat_t f_stat_update(stat_t cur, logic clr, logic rise,
                                          logic fall, logic rise_ovr,
                                          logic fall_ovr, logic wrap_hit);
    stat_t nx;
    nx = clr ? '0 : cur;
    if (rise) nx.rise_pend = 1'b1;
    if (fall) nx.fall_pend = 1'b1;
    if (rise_ovr) nx.rise_ovr = 1'b1;
    if (fall_ovr) nx.fall_ovr = 1'b1;
    if (wrap_hit) nx.wrapped = 1'b1;
    return nx;
  endfunction

endpackage

// File: rtl/ect_counter.sv
module ect_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  // The counter returns to zero on the coming edge.
  assign wrap_o = (cnt_q == CNT_MAX);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == '0));
  p_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != CNT_MAX) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/ect_sync_edge.sv
module ect_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign rise_o =  stage_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stage_q[STAGES-1] &  prev_q;

  // After an edge, the detector sees a steady level on the next cycle.
  p_single_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ect_regs.sv
module ect_regs
  import ect_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_o
);
  logic [CNT_W-1:0] rise_q, fall_q;
  logic             rise_unrd, fall_unrd, wrap_seen;
  stat_t            st_q, st_n;
  logic             rd_rise, rd_fall, rd_stat;
  logic             rise_ovr_evt, fall_ovr_evt, wrap_hit;

  assign rd_rise = rd_en && (rd_addr == A_RISE);
  assign rd_fall = rd_en && (rd_addr == A_FALL);
  assign rd_stat = rd_en && (rd_addr == A_STAT);

  // Named events for the status update and the assertions.
  assign rise_ovr_evt = rise_i && rise_unrd && !rd_rise;
  assign fall_ovr_evt = fall_i && fall_unrd && !rd_fall;
  assign wrap_hit     = (rise_i || fall_i) && wrap_seen;

  always_comb st_n = f_stat_update(st_q, rd_stat, rise_i, fall_i,
                                   rise_ovr_evt, fall_ovr_evt, wrap_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q    <= '0;
      fall_q    <= '0;
      rise_unrd <= 1'b0;
      fall_unrd <= 1'b0;
      wrap_seen <= 1'b0;
      st_q      <= '0;
    end else begin
      st_q <= st_n;
      if (rise_i) rise_q <= cnt_i;
      if (fall_i) fall_q <= cnt_i;
      rise_unrd <= rise_i ? 1'b1 : (rd_rise ? 1'b0 : rise_unrd);
      fall_unrd <= fall_i ? 1'b1 : (rd_fall ? 1'b0 : fall_unrd);
      if (rise_i || fall_i) wrap_seen <= wrap_i;
      else if (wrap_i)      wrap_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (rd_addr)
          A_RISE:  rd_data <= rise_q;
          A_FALL:  rd_data <= fall_q;
          A_STAT:  rd_data <= CNT_W'(st_q);
          default: rd_data <= cnt_i;
        endcase
      end
    end
  end

  assign irq_o = st_q.rise_pend | st_q.fall_pend;

  p_rise_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> (rise_q == $past(cnt_i)));
  p_fall_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_i |=> (fall_q == $past(cnt_i)));
  p_fall_keeps_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && !rise_i) |=> $stable(rise_q));
  p_irq_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i || fall_i) |=> irq_o);
  p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !rise_i && !fall_i) |=> !irq_o);
  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ovr_evt |=> st_q.rise_ovr);
  p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  logic [CNT_W-1:0] cnt;
  logic             wrap, rise_evt, fall_evt;

  ect_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .wrap_o(wrap)
  );

  ect_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(cap_in),
    .rise_o(rise_evt), .fall_o(fall_evt)
  );

  ect_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_evt), .fall_i(fall_evt),
    .cnt_i(cnt), .wrap_i(wrap), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq)
  );
endmodule

// File: tb/tb_edge_capture_timer.sv
`timescale 1ns/1ps
module tb_edge_capture_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_in = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = 2'd0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] tick = 16'd0;  // cycle count since reset, kept by the bench

  typedef struct {
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  edge_capture_timer dut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) tick <= rst_n ? tick + 16'd1 : 16'd0;

  task automatic check(input logic [15:0] act, input logic [15:0] exp,
                       input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item for each read result.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 actual=unexpected_read expected=none");
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(rd_data, it.exp, it.req);
      end
    end
  end

  // Driver: queues the expected value and issues a one-cycle read.
  task automatic do_read(input logic [1:0] a, input logic [15:0] exp,
                         input string req);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic read_count(input string req);
    item_t it;
    @(negedge clk);
    it.exp = tick; it.req = req;
    sb_q.push_back(it);
    rd_en = 1'b1; rd_addr = 2'd3;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Drives a level at a negedge and returns the expected stamp.
  task automatic drive_edge(input logic lvl, input int hold,
                            output logic [15:0] stamp);
    @(negedge clk);
    cap_in = lvl;
    stamp = tick + 16'd2;
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [15:0] r1, f1, r2, f2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check({15'd0, irq}, 16'd0, "R1 irq");
    do_read(2'd0, 16'd0, "R1 rise reg");
    do_read(2'd1, 16'd0, "R1 fall reg");
    do_read(2'd2, 16'd0, "R1 status");
    read_count("R2 count");

    // R3, R5: rising edge, irq within 3 clocks
    @(negedge clk);
    cap_in = 1'b1; r1 = tick + 16'd2;
    repeat (2) @(negedge clk);
    check({15'd0, irq}, 16'd0, "R5 irq before capture");
    @(negedge clk);
    check({15'd0, irq}, 16'd1, "R5 irq after rise");
    repeat (3) @(negedge clk);
    // R4: falling edge into the second register
    drive_edge(1'b0, 6, f1);
    do_read(2'd0, r1, "R3 rise stamp");
    do_read(2'd1, f1, "R4 fall stamp");
    do_read(2'd2, 16'h0003, "R5 pending bits");
    @(negedge clk);
    check({15'd0, irq}, 16'd0, "R6 irq cleared by status read");
    do_read(2'd2, 16'h0000, "R6 status cleared");

    // R10, R8: minimum-width pulses, two of each edge without reads
    drive_edge(1'b1, 4, r1);
    drive_edge(1'b0, 4, f1);
    drive_edge(1'b1, 4, r2);
    drive_edge(1'b0, 6, f2);
    do_read(2'd0, r2, "R10 second rise stamp");
    do_read(2'd1, f2, "R10 second fall stamp");
    do_read(2'd2, 16'h001B, "R8 overrun bits");
    do_read(2'd2, 16'h0000, "R6 overrun cleared");
    check(r2 - r1, 16'd8, "R10 bench period");

    // R7: capture after a counter wrap
    repeat (66000) @(negedge clk);
    drive_edge(1'b1, 6, r1);
    drive_edge(1'b0, 6, f1);
    do_read(2'd2, 16'h0007, "R7 overflow bit");
    do_read(2'd0, r1, "R3 stamp after wrap");
    read_count("R2 count after wrap");
    do_read(2'd2, 16'h0000, "R7 overflow cleared");

    repeat (4) @(negedge clk);
    check(16'(sb_q.size()), 16'd0, "R9 reads answered");
    finish_run();
  end
endmodule